// File: doc/BRIEF.md
# ADC External-Sync Conversion Sequencer

This block decides when an analog conversion begins. Commands arrive on a simple valid-qualified port, each carrying an operation code, a modifier nibble and a multiplexor address. A write or initialize-read command in which modifier bit 3 (value 8) is set puts the block into externally synchronized mode. The same two commands without that bit put it into program mode. Every accepted command of either kind rewrites the mode.

In program mode an accepted command closes the multiplexor switch at once. In externally synchronized mode the block first raises a ready signal and holds the switch open. It waits for an asynchronous start pulse from the outside device, which it synchronizes and edge-detects. Only then does it close the switch. The switch then settles for a set number of cycles, a one-cycle convert-start pulse is issued, and the conversion runs for a set number of cycles. A one-cycle result handoff follows, carrying the address that was converted.

Addresses below the channel count are normal inputs. One reserved address, 0x13E8, lies above that range and selects the calibration input; it is accepted in either mode. Commands that arrive while a sequence runs are refused with a busy response. Start pulses that arrive when none is awaited are ignored and counted.

Top module: `adc_sync_sequencer`

## Requirements
- R1: During and just after reset, all handshake, switch, start and result outputs are 0, the mode is program mode (ext_mode = 0), and the error count is 0.
- R2: When idle, a write (cmd_op = 01) or initialize-read (cmd_op = 10) with a valid address is acknowledged by a one-cycle cmd_ack in the next cycle. ext_mode then equals cmd_mod bit 3, and no other modifier bit affects the mode.
- R3: Operation codes 00 and 11 are ignored: no response pulse, no mode change and no switch actuation.
- R4: In externally synchronized mode, sync_ready is high from the cycle of cmd_ack until a start pulse is detected, and mux_enable stays low throughout that time.
- R5: After the external start input rises, mux_enable rises in the same cycle that sync_ready falls.
- R6: In program mode sync_ready is never asserted, and mux_enable is high in the same cycle as cmd_ack.
- R7: conv_start is a single-cycle pulse. It comes after exactly SETTLE_CYC cycles of mux_enable, and mux_enable stays high while it is asserted.
- R8: res_valid is a single-cycle pulse CONV_CYC cycles after conv_start. mux_enable is low in that cycle, and res_addr carries the accepted command's address.
- R9: Address 0x13E8 is accepted in both modes. cal_select is high whenever the switch is enabled for it, and res_cal marks its result.
- R10: An address at or above NUM_CH, other than 0x13E8, gives a one-cycle cmd_bad_addr instead of cmd_ack. The mode does not change and the switch is not actuated.
- R11: A write or initialize-read received while a sequence runs gives a one-cycle cmd_busy. The mode is left unchanged and the running conversion completes with its original address.
- R12: A detected start pulse outside the ready-wait phase is ignored, and it increments sync_err_cnt, which saturates at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Operation: 01 write, 10 initialize-read, others ignored |
| cmd_mod | input | 4 | Modifier; bit 3 selects externally synchronized mode |
| cmd_addr | input | 16 | Multiplexor address |
| cmd_ack | output | 1 | Command accepted (pulse) |
| cmd_busy | output | 1 | Command refused, sequence running (pulse) |
| cmd_bad_addr | output | 1 | Command refused, address invalid (pulse) |
| ext_mode | output | 1 | Current mode, 1 = externally synchronized |
| ext_sync_in | input | 1 | Asynchronous external start input |
| sync_ready | output | 1 | Waiting for the external start |
| mux_enable | output | 1 | Multiplexor switch closed |
| mux_addr | output | 16 | Address driven to the switch, 0 when open |
| cal_select | output | 1 | Calibration input switched in |
| conv_start | output | 1 | Convert-start pulse |
| res_valid | output | 1 | Result handoff pulse |
| res_addr | output | 16 | Address of the finished conversion |
| res_cal | output | 1 | Finished conversion was the calibration input |
| sync_err_cnt | output | 4 | Saturating count of unexpected start pulses |

## Verification
Some properties are checked on every cycle. The switch stays open while ready is shown, and ready appears only in externally synchronized mode. The start and result strobes last one cycle each, the start strobe lies inside the switch window, and the result strobe lies outside it. The three command responses never coincide, the mode holds while the switch is closed, the error count never falls, and the calibration flag always comes with the reserved address. Other behaviour only the bench's scenarios can show. This includes the exact settle and convert lengths and the mode chosen by each modifier pattern. It also covers refusal of bad addresses and busy commands without side effects, the address carried to each result, and saturation of the error count.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int ADDR_W       = 16;
    localparam int OP_W         = 2;
    localparam int MOD_W        = 4;
    localparam int SYNC_MOD_BIT = 3;
    localparam logic [ADDR_W-1:0] CAL_ADDR = 16'h13E8;

    typedef enum logic [OP_W-1:0] {
        OP_NOP       = 2'b00,
        OP_WRITE     = 2'b01,
        OP_INIT_READ = 2'b10,
        OP_RSVD      = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READY_WAIT,
        ST_SETTLE,
        ST_CONVERT,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic start;
        logic ext;
        logic cal;
        logic bad_addr;
    } cmd_dec_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              cal;
    } sel_t;

    function automatic logic is_conv_op(input logic [OP_W-1:0] op);
        return (op == OP_WRITE) || (op == OP_INIT_READ);
    endfunction

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_sync_edge.sv
module adc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic pulse
);
    logic [STAGES-1:0] shift_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            last_q  <= 1'b0;
        end else begin
            shift_q <= {shift_q[STAGES-2:0], async_in};
            last_q  <= shift_q[STAGES-1];
        end
    end

    assign pulse = shift_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/adc_cmd_decode.sv
module adc_cmd_decode
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH = 256
) (
    input  logic              cmd_valid,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [MOD_W-1:0]  cmd_mod,
    input  logic [ADDR_W-1:0] cmd_addr,
    output cmd_dec_t          dec
);
    localparam logic [ADDR_W:0] CH_LIMIT = (ADDR_W+1)'(NUM_CH);

    logic in_range;
    logic cal_hit;

    always_comb begin
        in_range     = {1'b0, cmd_addr} < CH_LIMIT;
        cal_hit      = (cmd_addr == CAL_ADDR);
        dec.start    = cmd_valid && is_conv_op(cmd_op);
        dec.ext      = cmd_mod[SYNC_MOD_BIT];
        dec.cal      = cal_hit;
        dec.bad_addr = !(in_range || cal_hit);
    end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int SETTLE_CYC = 4,
    parameter int CONV_CYC   = 12,
    parameter int ERR_W      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_dec_t          dec,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              sync_pulse,
    output logic              ack,
    output logic              busy,
    output logic              bad_addr,
    output logic              ext_mode,
    output logic              ready,
    output logic              mux_en,
    output sel_t              sel,
    output logic              start,
    output logic              done,
    output logic [ERR_W-1:0]  err_cnt
);
    localparam int MAXC  = max_of(SETTLE_CYC, CONV_CYC);
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] CONV_LD   = CNT_W'(CONV_CYC - 1);
    localparam logic [ERR_W-1:0] ERR_MAX   = '1;

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             start_q, start_d;
    logic             ack_q, busy_q, bad_q, ext_q;
    sel_t             sel_q;
    logic [ERR_W-1:0] err_q;
    logic             idle;
    logic             accept;

    assign idle   = (state_q == ST_IDLE);
    assign accept = idle && dec.start && !dec.bad_addr;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        start_d = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = dec.ext ? ST_READY_WAIT : ST_SETTLE;
                    cnt_d   = SETTLE_LD;
                end
            end
            ST_READY_WAIT: begin
                if (sync_pulse) begin
                    state_d = ST_SETTLE;
                    cnt_d   = SETTLE_LD;
                end
            end
            ST_SETTLE: begin
                if (cnt_q == '0) begin
                    state_d = ST_CONVERT;
                    cnt_d   = CONV_LD;
                    start_d = 1'b1;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_CONVERT: begin
                if (cnt_q == '0) begin
                    state_d = ST_DONE;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            start_q <= 1'b0;
            ack_q   <= 1'b0;
            busy_q  <= 1'b0;
            bad_q   <= 1'b0;
            ext_q   <= 1'b0;
            sel_q   <= '0;
            err_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            start_q <= start_d;
            ack_q   <= accept;
            busy_q  <= dec.start && !idle;
            bad_q   <= dec.start && idle && dec.bad_addr;
            if (accept) begin
                ext_q      <= dec.ext;
                sel_q.addr <= cmd_addr;
                sel_q.cal  <= dec.cal;
            end
            if (sync_pulse && (state_q != ST_READY_WAIT) && (err_q != ERR_MAX)) begin
                err_q <= err_q + ERR_W'(1);
            end
        end
    end

    assign ack      = ack_q;
    assign busy     = busy_q;
    assign bad_addr = bad_q;
    assign ext_mode = ext_q;
    assign ready    = (state_q == ST_READY_WAIT);
    assign mux_en   = (state_q == ST_SETTLE) || (state_q == ST_CONVERT);
    assign sel      = sel_q;
    assign start    = start_q;
    assign done     = (state_q == ST_DONE);
    assign err_cnt  = err_q;
endmodule

// File: rtl/adc_sync_sequencer.sv
module adc_sync_sequencer
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH      = 256,
    parameter int SETTLE_CYC  = 4,
    parameter int CONV_CYC    = 12,
    parameter int SYNC_STAGES = 2,
    parameter int ERR_W       = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [3:0]        cmd_mod,
    input  logic [15:0]       cmd_addr,
    output logic              cmd_ack,
    output logic              cmd_busy,
    output logic              cmd_bad_addr,
    output logic              ext_mode,
    input  logic              ext_sync_in,
    output logic              sync_ready,
    output logic              mux_enable,
    output logic [15:0]       mux_addr,
    output logic              cal_select,
    output logic              conv_start,
    output logic              res_valid,
    output logic [15:0]       res_addr,
    output logic              res_cal,
    output logic [ERR_W-1:0]  sync_err_cnt
);
    cmd_dec_t dec;
    logic     sync_pulse;
    logic     mux_en;
    logic     done;
    sel_t     sel;

    adc_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_mod   (cmd_mod),
        .cmd_addr  (cmd_addr),
        .dec       (dec)
    );

    adc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (ext_sync_in),
        .pulse    (sync_pulse)
    );

    adc_seq_fsm #(
        .SETTLE_CYC (SETTLE_CYC),
        .CONV_CYC   (CONV_CYC),
        .ERR_W      (ERR_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .dec        (dec),
        .cmd_addr   (cmd_addr),
        .sync_pulse (sync_pulse),
        .ack        (cmd_ack),
        .busy       (cmd_busy),
        .bad_addr   (cmd_bad_addr),
        .ext_mode   (ext_mode),
        .ready      (sync_ready),
        .mux_en     (mux_en),
        .sel        (sel),
        .start      (conv_start),
        .done       (done),
        .err_cnt    (sync_err_cnt)
    );

    assign mux_enable = mux_en;
    assign mux_addr   = mux_en ? sel.addr : '0;
    assign cal_select = mux_en & sel.cal;
    assign res_valid  = done;
    assign res_addr   = done ? sel.addr : '0;
    assign res_cal    = done & sel.cal;
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker
    import adc_seq_pkg::*;
#(
    parameter int ERR_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_ack,
    input logic             cmd_busy,
    input logic             cmd_bad_addr,
    input logic             ext_mode,
    input logic             sync_ready,
    input logic             mux_enable,
    input logic [15:0]      mux_addr,
    input logic             cal_select,
    input logic             conv_start,
    input logic             res_valid,
    input logic [ERR_W-1:0] sync_err_cnt
);
    AST_READY_SWITCH_OPEN: assert property (@(posedge clk) disable iff (rst)
        sync_ready |-> !mux_enable); // R4
    AST_READY_NEEDS_EXT: assert property (@(posedge clk) disable iff (rst)
        sync_ready |-> ext_mode); // R6
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start); // R7
    AST_START_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> mux_enable); // R7
    AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid); // R8
    AST_RESULT_SWITCH_OPEN: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !mux_enable); // R8
    AST_CAL_ADDR_MATCH: assert property (@(posedge clk) disable iff (rst)
        cal_select |-> (mux_enable && mux_addr == CAL_ADDR)); // R9
    AST_RESP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_ack, cmd_busy, cmd_bad_addr})); // R11
    AST_MODE_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        mux_enable |=> $stable(ext_mode)); // R11
    AST_ERR_NO_DECREASE: assert property (@(posedge clk) disable iff (rst)
        sync_err_cnt >= $past(sync_err_cnt)); // R12
endmodule

bind adc_sync_sequencer adc_seq_checker #(.ERR_W(ERR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_ack      (cmd_ack),
    .cmd_busy     (cmd_busy),
    .cmd_bad_addr (cmd_bad_addr),
    .ext_mode     (ext_mode),
    .sync_ready   (sync_ready),
    .mux_enable   (mux_enable),
    .mux_addr     (mux_addr),
    .cal_select   (cal_select),
    .conv_start   (conv_start),
    .res_valid    (res_valid),
    .sync_err_cnt (sync_err_cnt)
);

// File: tb/adc_sync_sequencer_bench.sv
module adc_sync_sequencer_bench;
    localparam int NUM_CH     = 256;
    localparam int SETTLE_CYC = 4;
    localparam int CONV_CYC   = 12;
    localparam int ERR_W      = 4;
    localparam logic [15:0] CAL = 16'h13E8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [3:0] cmd_mod = 4'h0;
    logic [15:0] cmd_addr = 16'h0;
    logic ext_sync_in = 1'b0;
    logic cmd_ack, cmd_busy, cmd_bad_addr, ext_mode, sync_ready, mux_enable;
    logic [15:0] mux_addr, res_addr;
    logic cal_select, conv_start, res_valid, res_cal;
    logic [ERR_W-1:0] sync_err_cnt;

    always #4 clk = ~clk;

    adc_sync_sequencer #(
        .NUM_CH(NUM_CH), .SETTLE_CYC(SETTLE_CYC), .CONV_CYC(CONV_CYC),
        .SYNC_STAGES(2), .ERR_W(ERR_W)
    ) u_adc_sync_sequencer (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_mod(cmd_mod), .cmd_addr(cmd_addr), .cmd_ack(cmd_ack),
        .cmd_busy(cmd_busy), .cmd_bad_addr(cmd_bad_addr), .ext_mode(ext_mode),
        .ext_sync_in(ext_sync_in), .sync_ready(sync_ready), .mux_enable(mux_enable),
        .mux_addr(mux_addr), .cal_select(cal_select), .conv_start(conv_start),
        .res_valid(res_valid), .res_addr(res_addr), .res_cal(res_cal),
        .sync_err_cnt(sync_err_cnt)
    );

    typedef struct { logic [15:0] addr; logic cal; } exp_t;
    exp_t sb_q[$];
    int n_chk = 0;
    int n_bad = 0;
    int n_res = 0;
    int n_exp = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            n_res++;
            if (sb_q.size() == 0) begin
                chk(0, "R8 unexpected result", longint'(res_addr), 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(res_addr == e.addr, "R8 result address", longint'(res_addr), longint'(e.addr));
                chk(res_cal == e.cal, "R9 result calibration flag", longint'(res_cal), longint'(e.cal));
            end
        end
    end

    task automatic issue(input logic [1:0] op, input logic [3:0] md,
                         input logic [15:0] ad, input bit exp_accept);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_mod = md; cmd_addr = ad;
        if (exp_accept) begin
            exp_t e;
            e.addr = ad; e.cal = (ad == CAL);
            sb_q.push_back(e);
            n_exp++;
        end
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00; cmd_mod = 4'h0; cmd_addr = 16'h0;
    endtask

    // starts at a negedge where mux_enable is in its first high cycle
    task automatic measure(input string tag);
        int k = 0;
        int j = 0;
        while (!conv_start && k < 100) begin
            chk(mux_enable == 1'b1, "R7 switch held during settle", longint'(mux_enable), 1);
            k++;
            @(negedge clk);
        end
        chk(k == SETTLE_CYC, {"R7 settle length ", tag}, k, SETTLE_CYC);
        chk(mux_enable == 1'b1, "R7 switch closed at start", longint'(mux_enable), 1);
        @(negedge clk);
        chk(conv_start == 1'b0, "R7 start is one cycle", longint'(conv_start), 0);
        j = 1;
        while (!res_valid && j < 200) begin
            j++;
            @(negedge clk);
        end
        chk(j == CONV_CYC, {"R8 convert length ", tag}, j, CONV_CYC);
        chk(mux_enable == 1'b0, "R8 switch open at handoff", longint'(mux_enable), 0);
        @(negedge clk);
    endtask

    // raise external start; returns at the negedge where mux_enable first is high
    task automatic fire_sync();
        int w = 0;
        ext_sync_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        ext_sync_in = 1'b0;
        while (!mux_enable && w < 20) begin
            chk(sync_ready == 1'b1, "R4 ready held until start", longint'(sync_ready), 1);
            w++;
            @(negedge clk);
        end
        chk(mux_enable == 1'b1, "R5 switch closes after start", longint'(mux_enable), 1);
        chk(sync_ready == 1'b0, "R5 ready drops with switch", longint'(sync_ready), 0);
    endtask

    task automatic stray_pulse();
        @(negedge clk);
        ext_sync_in = 1'b1;
        repeat (2) @(negedge clk);
        ext_sync_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset
        repeat (3) @(negedge clk);
        chk({cmd_ack, cmd_busy, cmd_bad_addr, sync_ready, mux_enable, conv_start, res_valid} == 7'b0,
            "R1 outputs in reset", 0, 0);
        chk(ext_mode == 1'b0 && sync_err_cnt == '0, "R1 mode and count in reset",
            longint'({ext_mode, sync_err_cnt}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk({cmd_ack, sync_ready, mux_enable, res_valid, ext_mode} == 5'b0,
            "R1 outputs after reset", 0, 0);

        // R2 R6 program mode write
        issue(2'b01, 4'h0, 16'd5, 1);
        chk(cmd_ack == 1'b1, "R2 write acknowledged", longint'(cmd_ack), 1);
        chk(ext_mode == 1'b0, "R2 program mode", longint'(ext_mode), 0);
        chk(mux_enable == 1'b1 && sync_ready == 1'b0, "R6 switch closes with ack",
            longint'({mux_enable, sync_ready}), 2);
        chk(mux_addr == 16'd5, "R6 switch address", longint'(mux_addr), 5);
        measure("prog");

        // R2 R4 R5 external mode initialize-read
        issue(2'b10, 4'h8, 16'd200, 1);
        chk(cmd_ack == 1'b1 && ext_mode == 1'b1, "R2 init-read enters external mode",
            longint'({cmd_ack, ext_mode}), 3);
        chk(sync_ready == 1'b1, "R4 ready with ack", longint'(sync_ready), 1);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(sync_ready == 1'b1 && mux_enable == 1'b0, "R4 waiting, switch open",
                longint'({sync_ready, mux_enable}), 2);
        end
        fire_sync();
        chk(mux_addr == 16'd200, "R5 switch address", longint'(mux_addr), 200);
        measure("ext");

        // R2 other modifier bits do not select external mode
        issue(2'b01, 4'h7, 16'd255, 1);
        chk(cmd_ack == 1'b1 && ext_mode == 1'b0, "R2 modifier 7 keeps program mode",
            longint'({cmd_ack, ext_mode}), 2);
        chk(mux_enable == 1'b1, "R6 switch closes", longint'(mux_enable), 1);
        measure("mod7");

        // R3 ignored operations
        issue(2'b00, 4'h8, 16'd3, 0);
        chk({cmd_ack, cmd_busy, cmd_bad_addr} == 3'b0, "R3 op 00 no response", 0, 0);
        issue(2'b11, 4'h8, 16'd3, 0);
        chk({cmd_ack, cmd_busy, cmd_bad_addr} == 3'b0, "R3 op 11 no response", 0, 0);
        repeat (3) @(negedge clk);
        chk(ext_mode == 1'b0 && mux_enable == 1'b0 && sync_ready == 1'b0,
            "R3 no mode change or actuation", longint'({ext_mode, mux_enable, sync_ready}), 0);

        // R9 calibration address, external mode
        issue(2'b01, 4'h8, CAL, 1);
        chk(cmd_ack == 1'b1 && ext_mode == 1'b1, "R9 calibration accepted external",
            longint'({cmd_ack, ext_mode}), 3);
        fire_sync();
        chk(cal_select == 1'b1 && mux_addr == CAL, "R9 calibration switched in",
            longint'({cal_select, mux_addr}), longint'({1'b1, CAL}));
        measure("cal");

        // R10 invalid addresses
        issue(2'b01, 4'h0, 16'd256, 0);
        chk(cmd_bad_addr == 1'b1 && cmd_ack == 1'b0, "R10 address 256 refused",
            longint'({cmd_bad_addr, cmd_ack}), 2);
        chk(ext_mode == 1'b1, "R10 mode unchanged", longint'(ext_mode), 1);
        issue(2'b10, 4'h0, 16'h13E7, 0);
        chk(cmd_bad_addr == 1'b1, "R10 address 13E7 refused", longint'(cmd_bad_addr), 1);
        repeat (2) @(negedge clk);
        chk(mux_enable == 1'b0 && sync_ready == 1'b0 && ext_mode == 1'b1,
            "R10 no actuation", longint'({mux_enable, sync_ready, ext_mode}), 1);

        // R11 busy rejection
        issue(2'b01, 4'h0, 16'd7, 1);
        chk(cmd_ack == 1'b1 && ext_mode == 1'b0, "R11 first command accepted",
            longint'({cmd_ack, ext_mode}), 2);
        issue(2'b10, 4'h8, 16'd9, 0);
        chk(cmd_busy == 1'b1 && cmd_ack == 1'b0, "R11 busy response",
            longint'({cmd_busy, cmd_ack}), 2);
        chk(ext_mode == 1'b0, "R11 mode unchanged while busy", longint'(ext_mode), 0);
        for (int i = 0; i < 100 && !res_valid; i++) @(negedge clk);
        @(negedge clk);

        // R9 calibration in program mode
        issue(2'b10, 4'h0, CAL, 1);
        chk(cmd_ack == 1'b1 && cal_select == 1'b1, "R9 calibration accepted program",
            longint'({cmd_ack, cal_select}), 3);
        measure("calprog");

        // R12 stray start pulses
        stray_pulse();
        chk(sync_err_cnt == 4'd1, "R12 stray pulse counted", longint'(sync_err_cnt), 1);
        chk(mux_enable == 1'b0 && sync_ready == 1'b0, "R12 stray pulse ignored",
            longint'({mux_enable, sync_ready}), 0);
        for (int i = 0; i < 20; i++) stray_pulse();
        chk(sync_err_cnt == 4'd15, "R12 count saturates", longint'(sync_err_cnt), 15);

        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0 && n_res == n_exp, "R8 every accepted command produced a result",
            n_res, n_exp);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule